// File: doc/BRIEF.md
# Periodic Interval Timer with Missed-Interval Flag

This block produces a periodic event from a free-running input clock. An external clock-enable is first divided by three or four to form an internal clock-enable pulse. A second divider then turns that pulse into a timer step once every 64 internal cycles, or once every 2 in a fast test mode. An 8-bit down counter takes these steps and, on each expiry, reloads itself from an interval register and raises an elapsed flag. One period is therefore 64 × N internal cycles, where an interval value of 0 counts as 256.

The elapsed flag stays set until the host clears it. If the counter expires again while the flag is still set, a separate missed flag records that an interval went unserviced. A single clear pulse drops both flags. The interrupt request is the elapsed flag gated by an enable. Writing the interval register alone does not disturb the interval in progress. A load-release strobe restarts the timer: it copies the register into the counter and zeroes the step divider, so the first period after a restart is exact to within one internal-clock phase.

Top module: `pit_timer`

## Requirements
- R1: `tick_int` is high only in cycles where `ext_en` is high. It pulses once per 3 `ext_en` cycles when `div4_sel`=0 and once per 4 when `div4_sel`=1.
- R2: With `test_mode`=0 and no restart, consecutive rising edges of `elapsed` (flag cleared between them) are exactly 64 × N `tick_int` pulses apart, where N is the interval value.
- R3: With `test_mode`=1 the spacing of R2 is 2 × N `tick_int` pulses.
- R4: An interval value of 0 gives the spacing of N = 256.
- R5: `elapsed` is set on expiry and stays set until `flag_clr`.
- R6: An expiry while `elapsed` is already set also sets `missed`. `missed` is never high without `elapsed`.
- R7: A `flag_clr` pulse with no expiry in the same cycle clears both `elapsed` and `missed` on the next cycle.
- R8: When `flag_clr` and an expiry fall in the same cycle, `elapsed` ends up 1 and `missed` ends up 0.
- R9: `irq` equals `elapsed` AND `irq_en`.
- R10: A write on `ivl_wr` does not change the interval in progress. The written value is used from the next reload on.
- R11: A `load_release` pulse reloads the counter from the interval register and zeroes the step divider. The next expiry then comes within (divide ratio − 1) cycles before a full period after the pulse.
- R12: After reset, `elapsed`, `missed` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | External clock-enable, the time base |
| div4_sel | input | 1 | 1 selects divide-by-4, 0 selects divide-by-3 |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wdata | input | 8 | Interval value (0 means 256) |
| load_release | input | 1 | Restart strobe: counter reload and step-divider clear |
| test_mode | input | 1 | Steps every 2 internal cycles instead of 64 |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the elapsed and missed flags |
| tick_int | output | 1 | Internal clock-enable pulse |
| elapsed | output | 1 | Interval elapsed flag |
| missed | output | 1 | Unserviced-interval error flag |
| irq | output | 1 | Interrupt request |

## Verification
The period is swept over both divide ratios, both step rates and several interval values, including 0. The measured cycle distance between events therefore separates an error in the prescaler from an error in the step divider or in the counter reload. A run with `ext_en` toggling at half rate shows whether the timer counts enable pulses rather than clock cycles. Three servicing patterns are used: prompt clearing, no clearing, and a clear placed exactly on the expiry cycle. Together they separate the missed-flag logic from the clear priority. A register write with and without a following restart separates the reload path from the restart path.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Flag pair kept together by the timer core.
   typedef struct packed {
      logic elapsed;
      logic missed;
   } pit_flags_t;

   // Width of a counter that must hold values 0..n-1.
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
   parameter int DIV_LO = 3,
   parameter int DIV_HI = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_en,
   input  logic hi_sel,
   output logic tick
);
   localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
   localparam int PW   = pit_pkg::cnt_width(DMAX);

   if (DIV_LO < 1 || DIV_HI < 1) begin : g_bad_div
      $error("pit_prescale: divide ratios must be at least 1");
   end

   logic [PW-1:0] ph_q;
   logic [PW-1:0] last;

   if (DIV_LO == DIV_HI) begin : g_fixed
      assign last = PW'(DIV_LO - 1);
   end else begin : g_sel
      assign last = hi_sel ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
   end

   assign tick = ext_en && (ph_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (ext_en) begin
         ph_q <= (ph_q >= last) ? '0 : ph_q + 1'b1;
      end
   end
endmodule

// File: rtl/pit_step.sv
module pit_step #(
   parameter int NORM_DIV = 64,
   parameter int FAST_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fast,
   input  logic restart,
   output logic step
);
   localparam int SW = pit_pkg::cnt_width(NORM_DIV);

   if (FAST_DIV < 1 || NORM_DIV < FAST_DIV) begin : g_bad_step
      $error("pit_step: need 1 <= FAST_DIV <= NORM_DIV");
   end

   logic [SW-1:0] sc_q;
   logic [SW-1:0] last;
   logic          wrap;

   if (FAST_DIV == 1) begin : g_fast_direct
      assign last = fast ? '0 : SW'(NORM_DIV - 1);
   end else begin : g_fast_count
      assign last = fast ? SW'(FAST_DIV - 1) : SW'(NORM_DIV - 1);
   end

   assign wrap = tick && (sc_q >= last);
   assign step = wrap && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q <= '0;
      end else if (restart) begin
         sc_q <= '0;
      end else if (tick) begin
         sc_q <= wrap ? '0 : sc_q + 1'b1;
      end
   end
endmodule

// File: rtl/pit_core.sv
module pit_core #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          restart,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   input  logic          clr,
   output pit_pkg::pit_flags_t flags
);
   if (CW < 2) begin : g_bad_cw
      $error("pit_core: counter width must be at least 2");
   end

   logic [CW-1:0] ivl_q;
   logic [CW-1:0] cnt_q;
   logic          expire;
   pit_pkg::pit_flags_t fl_q;

   // A count of 1 is the last step; 0 wraps to all-ones, so 0 acts as 2**CW.
   assign expire = step && !restart && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl_q <= '0;
      end else if (wr) begin
         ivl_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || expire) begin
         cnt_q <= ivl_q;
      end else if (step) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q <= '0;
      end else if (clr) begin
         fl_q.elapsed <= expire;
         fl_q.missed  <= 1'b0;
      end else if (expire) begin
         fl_q.elapsed <= 1'b1;
         fl_q.missed  <= fl_q.missed | fl_q.elapsed;
      end
   end

   assign flags = fl_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
   parameter int DIV_LO   = 3,
   parameter int DIV_HI   = 4,
   parameter int NORM_DIV = 64,
   parameter int FAST_DIV = 2,
   parameter int CW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ext_en,
   input  logic          div4_sel,
   input  logic          ivl_wr,
   input  logic [CW-1:0] ivl_wdata,
   input  logic          load_release,
   input  logic          test_mode,
   input  logic          irq_en,
   input  logic          flag_clr,
   output logic          tick_int,
   output logic          elapsed,
   output logic          missed,
   output logic          irq
);
   logic                step;
   pit_pkg::pit_flags_t flags;

   pit_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
      .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .hi_sel(div4_sel), .tick(tick_int)
   );

   pit_step #(.NORM_DIV(NORM_DIV), .FAST_DIV(FAST_DIV)) u_step (
      .clk(clk), .rst_n(rst_n), .tick(tick_int), .fast(test_mode),
      .restart(load_release), .step(step)
   );

   pit_core #(.CW(CW)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .restart(load_release),
      .wr(ivl_wr), .wdata(ivl_wdata), .clr(flag_clr), .flags(flags)
   );

   assign elapsed = flags.elapsed;
   assign missed  = flags.missed;
   assign irq     = flags.elapsed & irq_en;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic ext_en,
   input logic flag_clr,
   input logic irq_en,
   input logic tick_int,
   input logic elapsed,
   input logic missed,
   input logic irq
);
   p_tick_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_int |-> ext_en);
   p_tick_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_int |=> !tick_int);
   p_elapsed_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (elapsed && !flag_clr) |=> elapsed);
   p_miss_implies_elapsed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      missed |-> elapsed);
   p_miss_after_elapsed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(missed) |-> $past(elapsed));
   p_clear_drops_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !missed);
   p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (elapsed && irq_en));
   p_irq_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (elapsed && irq_en) |-> irq);
endmodule

bind pit_timer pit_timer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .flag_clr(flag_clr), .irq_en(irq_en),
   .tick_int(tick_int), .elapsed(elapsed), .missed(missed), .irq(irq)
);

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
module pit_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_en = 1'b1;
   logic       div4_sel = 1'b0;
   logic       ivl_wr = 1'b0;
   logic [7:0] ivl_wdata = '0;
   logic       load_release = 1'b0;
   logic       test_mode = 1'b0;
   logic       irq_en = 1'b0;
   logic       flag_clr = 1'b0;
   logic       tick_int, elapsed, missed, irq;

   int  checks = 0;
   int  fails  = 0;
   int  cyc    = 0;
   bit  half_rate = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) ext_en <= half_rate ? ~ext_en : 1'b1;

   pit_timer u_dut (
      .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .div4_sel(div4_sel),
      .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata), .load_release(load_release),
      .test_mode(test_mode), .irq_en(irq_en), .flag_clr(flag_clr),
      .tick_int(tick_int), .elapsed(elapsed), .missed(missed), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   task automatic wait_rise(output int t);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!elapsed && n < 20000);
      if (n >= 20000) check(1'b0, "watchdog", 0, 1);
      t = cyc;
   endtask

   task automatic clear();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic write_ivl(input logic [7:0] v);
      ivl_wr = 1'b1; ivl_wdata = v;
      @(negedge clk);
      ivl_wr = 1'b0;
   endtask

   task automatic restart();
      load_release = 1'b1;
      @(negedge clk);
      load_release = 1'b0;
   endtask

   function automatic int period(input bit d4, input bit tm, input int v);
      return (d4 ? 4 : 3) * (tm ? 2 : 64) * ((v == 0) ? 256 : v);
   endfunction

   // Settle a configuration, then measure one full period between rises.
   task automatic measure(input string req, input int exp);
      int t0, t1;
      clear();
      restart();
      wait_rise(t0);
      clear();
      wait_rise(t1);
      check((t1 - t0) == exp, req, t1 - t0, exp);
   endtask

   task automatic count_ticks(input int span, output int n);
      n = 0;
      for (int i = 0; i < span; i++) begin
         @(negedge clk);
         #1;
         if (tick_int) n++;
      end
   endtask

   initial begin
      int n, t0, t1, p;
      int vals[4] = '{1, 2, 3, 0};
      repeat (3) @(negedge clk);
      // R12: reset state
      check(elapsed == 0, "R12 elapsed", elapsed, 0);
      check(missed  == 0, "R12 missed", missed, 0);
      check(irq     == 0, "R12 irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: prescale ratios
      div4_sel = 0; count_ticks(24, n); check(n == 8, "R1 div3", n, 8);
      div4_sel = 1; count_ticks(24, n); check(n == 6, "R1 div4", n, 6);
      half_rate = 1; div4_sel = 0;
      count_ticks(24, n); check(n == 4, "R1 half-rate div3", n, 4);
      half_rate = 0;
      @(negedge clk);

      // R2/R3/R4: period sweep
      for (int d = 0; d < 2; d++) begin
         for (int tm = 0; tm < 2; tm++) begin
            for (int k = 0; k < 4; k++) begin
               if (tm == 0 && vals[k] == 0) continue;
               div4_sel = d[0]; test_mode = tm[0];
               write_ivl(8'(vals[k]));
               measure(tm ? ((vals[k] == 0) ? "R4 zero as 256" : "R3 test period")
                          : "R2 normal period",
                       period(d[0], tm[0], vals[k]));
            end
         end
      end
      // R2 with ext_en at half rate: period counts enable pulses
      div4_sel = 0; test_mode = 0; half_rate = 1;
      write_ivl(8'd1);
      measure("R2 half-rate", 2 * period(0, 0, 1));
      half_rate = 0;
      @(negedge clk);

      // R10: write takes effect at next reload only
      div4_sel = 0; test_mode = 1;
      write_ivl(8'd5);
      clear(); restart();
      wait_rise(t0); clear();
      write_ivl(8'd2);
      wait_rise(t1);
      check((t1 - t0) == period(0, 1, 5), "R10 old interval kept", t1 - t0, period(0, 1, 5));
      clear();
      wait_rise(t0);
      check((t0 - t1) == period(0, 1, 2), "R10 new interval used", t0 - t1, period(0, 1, 2));

      // R11: restart mid-interval reloads and realigns
      write_ivl(8'd20);
      clear();
      restart();
      wait_rise(t0); clear();
      repeat (37) @(negedge clk);
      restart();
      t1 = cyc;
      wait_rise(t0);
      p = period(0, 1, 20);
      check((t0 - t1) <= p && (t0 - t1) >= p - 2, "R11 restart", t0 - t1, p);

      // R5/R6/R9: unserviced interval
      write_ivl(8'd2);
      p = period(0, 1, 2);
      clear(); restart();
      wait_rise(t0);
      check(irq == 0, "R9 irq masked", irq, 0);
      irq_en = 1;
      #1;
      check(irq == 1, "R9 irq enabled", irq, 1);
      repeat (p - 1) @(negedge clk);
      check(elapsed == 1 && missed == 0, "R5 sticky before miss", missed, 0);
      @(negedge clk);
      check(missed == 1, "R6 missed set", missed, 1);
      check(elapsed == 1, "R5 elapsed held", elapsed, 1);

      // R7: clear drops both
      clear();
      check(elapsed == 0, "R7 elapsed cleared", elapsed, 0);
      check(missed == 0, "R7 missed cleared", missed, 0);
      check(irq == 0, "R9 irq follows clear", irq, 0);

      // R8: clear on the expiry cycle
      wait_rise(t0);
      repeat (p - 1) @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check(elapsed == 1, "R8 elapsed wins", elapsed, 1);
      check(missed == 0, "R8 missed stays clear", missed, 0);

      finish_run();
   end
endmodule